// File: doc/BRIEF.md
# SDLC Frame Status Queue

This block sits beside an SDLC/HDLC receiver. A DMA engine drains received data bytes to memory, and the CPU checks each frame's length and error state later, after the data has moved on. While the queue is enabled and the receiver runs in SDLC mode, the block counts received bytes in a 14-bit counter. On every closing flag it files the count, together with the three residue bits, the receive-overrun bit and the CRC-error bit, as one 19-bit record in a ten-slot ring. The counter then restarts at zero for the next frame, which may follow at once.

Software reads the oldest record through three byte-wide views. The status view carries the queued error and residue bits, with end-of-frame forced high and the other bits showing live receiver status. The low-count view carries count bits 7:0. The high-count view carries count bits 13:8, a "record available" bit and a sticky "queue overflowed" bit. Completing the status read retires the oldest record. When the queue is turned off, the status view passes live status through unchanged.

Top module: `sdlc_frame_status_queue`

## Requirements
- R1: While active (queue enabled and SDLC mode), each cycle with `byte_stb` high adds one to the frame byte counter. A cycle with `flag_stb` high files the current count and restarts the counter at 0, and a byte strobe in that same cycle is not counted.
- R2: The byte counter wraps from 16383 to 0. It holds 0 whenever the block is not active, so bytes and flags seen outside SDLC mode or with the queue disabled neither count nor file a record.
- R3: Each filed record holds the byte count and the live residue, overrun and CRC-error bits sampled in the flag cycle, and records are read back oldest first.
- R4: The ring holds at most DEPTH (10) records. A flag that arrives while it is full is discarded, the stored records are kept unchanged, and bit 7 of `count_hi_reg` becomes 1.
- R5: The overflow bit stays set until a block reset (`rst`) or until `queue_en` goes low; popping records does not clear it.
- R6: Bit 6 of `count_hi_reg` is 1 exactly when the enabled queue holds at least one record.
- R7: `count_lo_reg` gives bits 7:0 of the oldest record's count, and `count_hi_reg[5:0]` gives bits 13:8; with an empty queue both fields read 0.
- R8: With the queue enabled, `status_reg` is {1 (end of frame), oldest CRC error, oldest overrun, live parity error, oldest residue[2:0], live all-sent} from bit 7 down to bit 0. The queued fields read 0 when the queue is empty.
- R9: With `queue_en` low, `status_reg` equals {live_eof, live_crc_err, live_overrun, live_parity_err, live_residue[2:0], live_all_sent}, both count views read 0, and the queue is emptied.
- R10: A cycle with `stat_rd_done` high retires the oldest record when the enabled queue is not empty and is ignored when it is empty. Slot order wraps from the last slot back to the first, so records stay in order across any number of fills and drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| queue_en | input | 1 | Turns the status queue on; low clears it |
| sdlc_mode | input | 1 | Receiver is operating in SDLC mode |
| byte_stb | input | 1 | One received data byte this cycle |
| flag_stb | input | 1 | Closing flag detected this cycle |
| live_all_sent | input | 1 | Live transmitter all-sent status |
| live_residue | input | 3 | Live residue code |
| live_parity_err | input | 1 | Live parity error status |
| live_overrun | input | 1 | Live receive overrun status |
| live_crc_err | input | 1 | Live CRC/framing error status |
| live_eof | input | 1 | Live end-of-frame status |
| stat_rd_done | input | 1 | Status read of the oldest record completed |
| status_reg | output | 8 | Receive status view |
| count_lo_reg | output | 8 | Low count byte of oldest record |
| count_hi_reg | output | 8 | High count bits, available and overflow flags |

## Verification
The bench builds the block at its default parameters: ten slots and a 14-bit counter. At this size every slot, the pointer wrap and both ends of the count range (0, 16383 and the roll past 16383) fall within a short run. It sweeps all 256 live status patterns through the disabled path and every residue code through a filled queue. It overflows the ring and confirms which records survive, then drains and refills it several times so the slot order wraps at shifting positions. Same-cycle byte and flag strobes, pops on an empty queue, and strobes outside SDLC mode are driven separately.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

    localparam int COUNT_W = 14;
    localparam int LO_W    = 8;
    localparam int HI_W    = COUNT_W - LO_W;

    typedef struct packed {
        logic [2:0] residue;
        logic       overrun;
        logic       crc_err;
    } frame_flags_t;

    typedef struct packed {
        logic [COUNT_W-1:0] count;
        frame_flags_t       flags;
    } frame_rec_t;

    typedef struct packed {
        logic       eof;
        logic       crc_err;
        logic       overrun;
        logic       parity_err;
        logic [2:0] residue;
        logic       all_sent;
    } live_stat_t;

    function automatic logic [7:0] pack_status(input live_stat_t s);
        return {s.eof, s.crc_err, s.overrun, s.parity_err, s.residue, s.all_sent};
    endfunction

    function automatic frame_flags_t flags_of(input live_stat_t s);
        frame_flags_t f;
        f.residue = s.residue;
        f.overrun = s.overrun;
        f.crc_err = s.crc_err;
        return f;
    endfunction

endpackage

// File: rtl/fsq_byte_counter.sv
module fsq_byte_counter
    import fsq_pkg::*;
#(
    parameter int W = COUNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         active,
    input  logic         byte_stb,
    input  logic         flag_stb,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            count <= '0;
        end else if (flag_stb) begin
            count <= '0;
        end else if (byte_stb) begin
            count <= count + 1'b1;
        end
    end

    p_count_clear_r1: assert property (@(posedge clk) disable iff (rst)
        active && flag_stb |=> count == '0);

    p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
        active && byte_stb && !flag_stb |=> count == $past(count) + 1'b1);

    p_count_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !active |=> count == '0);

endmodule

// File: rtl/fsq_ring.sv
module fsq_ring
    import fsq_pkg::*;
#(
    parameter int DEPTH = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       enable,
    input  logic                       push,
    input  frame_rec_t                 push_rec,
    input  logic                       pop,
    output frame_rec_t                 head_rec,
    output logic                       avail,
    output logic                       ovf
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);

    frame_rec_t        mem [DEPTH];
    logic [PTR_W-1:0]  head_ptr;
    logic [PTR_W-1:0]  tail_ptr;
    logic [OCC_W-1:0]  occ;
    logic              full;
    logic              empty;
    logic              do_push;
    logic              do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign full    = (occ == FULL_OCC);
    assign empty   = (occ == '0);
    assign do_push = enable && push && !full;
    assign do_pop  = enable && pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[tail_ptr] <= push_rec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            head_ptr <= '0;
            tail_ptr <= '0;
            occ      <= '0;
            ovf      <= 1'b0;
        end else begin
            if (do_push) begin
                tail_ptr <= step(tail_ptr);
            end
            if (do_pop) begin
                head_ptr <= step(head_ptr);
            end
            unique case ({do_push, do_pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
            if (push && full) begin
                ovf <= 1'b1;
            end
        end
    end

    assign head_rec = mem[head_ptr];
    assign avail    = !empty;

    p_occ_bound_r4: assert property (@(posedge clk) disable iff (rst)
        occ <= FULL_OCC);

    p_full_keeps_r4: assert property (@(posedge clk) disable iff (rst)
        enable && full && push && !pop |=> (occ == FULL_OCC) && ovf && $stable(head_ptr));

    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        enable && ovf |=> ovf);

    p_pop_empty_r10: assert property (@(posedge clk) disable iff (rst)
        enable && empty && pop && !push |=> empty);

    p_disable_clears_r9: assert property (@(posedge clk) disable iff (rst)
        !enable |=> empty && !ovf);

endmodule

// File: rtl/fsq_view_mux.sv
module fsq_view_mux
    import fsq_pkg::*;
(
    input  logic       enable,
    input  live_stat_t live,
    input  frame_rec_t head_rec,
    input  logic       avail,
    input  logic       ovf,
    output logic [7:0] status_reg,
    output logic [7:0] count_lo_reg,
    output logic [7:0] count_hi_reg
);

    frame_rec_t shown;

    always_comb begin
        shown = avail ? head_rec : '0;
        if (enable) begin
            status_reg   = {1'b1, shown.flags.crc_err, shown.flags.overrun,
                            live.parity_err, shown.flags.residue, live.all_sent};
            count_lo_reg = shown.count[LO_W-1:0];
            count_hi_reg = {ovf, avail, shown.count[COUNT_W-1:LO_W]};
        end else begin
            status_reg   = pack_status(live);
            count_lo_reg = '0;
            count_hi_reg = '0;
        end
    end

endmodule

// File: rtl/sdlc_frame_status_queue.sv
module sdlc_frame_status_queue
    import fsq_pkg::*;
#(
    parameter int DEPTH = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       queue_en,
    input  logic       sdlc_mode,
    input  logic       byte_stb,
    input  logic       flag_stb,
    input  logic       live_all_sent,
    input  logic [2:0] live_residue,
    input  logic       live_parity_err,
    input  logic       live_overrun,
    input  logic       live_crc_err,
    input  logic       live_eof,
    input  logic       stat_rd_done,
    output logic [7:0] status_reg,
    output logic [7:0] count_lo_reg,
    output logic [7:0] count_hi_reg
);

    logic               active;
    logic [COUNT_W-1:0] byte_count;
    live_stat_t         live;
    frame_rec_t         new_rec;
    frame_rec_t         head_rec;
    logic               avail;
    logic               ovf;

    assign active = queue_en && sdlc_mode;

    always_comb begin
        live.eof        = live_eof;
        live.crc_err    = live_crc_err;
        live.overrun    = live_overrun;
        live.parity_err = live_parity_err;
        live.residue    = live_residue;
        live.all_sent   = live_all_sent;
        new_rec.count   = byte_count;
        new_rec.flags   = flags_of(live);
    end

    fsq_byte_counter #(.W(COUNT_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .byte_stb (byte_stb),
        .flag_stb (flag_stb),
        .count    (byte_count)
    );

    fsq_ring #(.DEPTH(DEPTH)) u_ring (
        .clk      (clk),
        .rst      (rst),
        .enable   (queue_en),
        .push     (active && flag_stb),
        .push_rec (new_rec),
        .pop      (stat_rd_done),
        .head_rec (head_rec),
        .avail    (avail),
        .ovf      (ovf)
    );

    fsq_view_mux u_mux (
        .enable       (queue_en),
        .live         (live),
        .head_rec     (head_rec),
        .avail        (avail),
        .ovf          (ovf),
        .status_reg   (status_reg),
        .count_lo_reg (count_lo_reg),
        .count_hi_reg (count_hi_reg)
    );

    p_eof_forced_r8: assert property (@(posedge clk) disable iff (rst)
        queue_en |-> status_reg[7]);

    p_idle_views_r9: assert property (@(posedge clk) disable iff (rst)
        !queue_en |-> (count_lo_reg == 8'h00) && (count_hi_reg == 8'h00));

    p_inactive_no_file_r2: assert property (@(posedge clk) disable iff (rst)
        queue_en && !sdlc_mode && !stat_rd_done |=> $stable(count_hi_reg[6]) && $stable(count_lo_reg));

endmodule

// File: tb/sdlc_frame_status_queue_bench.sv
module sdlc_frame_status_queue_bench;

    localparam int CLK_PERIOD = 10;
    localparam int D = 10;
    localparam int CMAX = 16384;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic queue_en = 1'b0;
    logic sdlc_mode = 1'b0;
    logic byte_stb = 1'b0;
    logic flag_stb = 1'b0;
    logic live_all_sent = 1'b0;
    logic [2:0] live_residue = 3'd0;
    logic live_parity_err = 1'b0;
    logic live_overrun = 1'b0;
    logic live_crc_err = 1'b0;
    logic live_eof = 1'b0;
    logic stat_rd_done = 1'b0;
    logic [7:0] status_reg;
    logic [7:0] count_lo_reg;
    logic [7:0] count_hi_reg;

    int n_checks = 0;
    int n_fail = 0;

    int mq_cnt [D];
    logic [4:0] mq_fl [D];
    int mh = 0;
    int mn = 0;
    logic movf = 1'b0;
    int mcount = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdlc_frame_status_queue #(.DEPTH(D)) u_sdlc_frame_status_queue (
        .clk(clk), .rst(rst), .queue_en(queue_en), .sdlc_mode(sdlc_mode),
        .byte_stb(byte_stb), .flag_stb(flag_stb),
        .live_all_sent(live_all_sent), .live_residue(live_residue),
        .live_parity_err(live_parity_err), .live_overrun(live_overrun),
        .live_crc_err(live_crc_err), .live_eof(live_eof),
        .stat_rd_done(stat_rd_done), .status_reg(status_reg),
        .count_lo_reg(count_lo_reg), .count_hi_reg(count_hi_reg)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        logic [7:0] st, lo, hi;
        if (!queue_en) begin
            st = {live_eof, live_crc_err, live_overrun, live_parity_err, live_residue, live_all_sent};
            lo = 8'h00;
            hi = 8'h00;
        end else if (mn > 0) begin
            st = {1'b1, mq_fl[mh][0], mq_fl[mh][1], live_parity_err, mq_fl[mh][4:2], live_all_sent};
            lo = 8'(mq_cnt[mh] % 256);
            hi = {movf, 1'b1, 6'(mq_cnt[mh] / 256)};
        end else begin
            st = {1'b1, 2'b00, live_parity_err, 3'b000, live_all_sent};
            lo = 8'h00;
            hi = {movf, 7'b0};
        end
        chk(req, "status", status_reg, st);
        chk(req, "count_lo", count_lo_reg, lo);
        chk(req, "count_hi", count_hi_reg, hi);
    endtask

    task automatic send_bytes(input int n);
        if (n > 0) begin
            byte_stb = 1'b1;
            repeat (n) @(negedge clk);
            byte_stb = 1'b0;
            if (queue_en && sdlc_mode) mcount = (mcount + n) % CMAX;
        end
    endtask

    task automatic end_frame(input logic [2:0] res, input logic ovr, input logic crc, input logic with_byte);
        live_residue = res;
        live_overrun = ovr;
        live_crc_err = crc;
        flag_stb = 1'b1;
        byte_stb = with_byte;
        @(negedge clk);
        flag_stb = 1'b0;
        byte_stb = 1'b0;
        if (queue_en && sdlc_mode) begin
            if (mn == D) begin
                movf = 1'b1;
            end else begin
                mq_cnt[(mh + mn) % D] = mcount;
                mq_fl[(mh + mn) % D] = {res, ovr, crc};
                mn++;
            end
            mcount = 0;
        end
    endtask

    task automatic pop_one();
        stat_rd_done = 1'b1;
        @(negedge clk);
        stat_rd_done = 1'b0;
        if (queue_en && mn > 0) begin
            mh = (mh + 1) % D;
            mn--;
        end
    endtask

    task automatic clear_model();
        mh = 0; mn = 0; movf = 1'b0; mcount = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R9 reset state");

        // R9: live passthrough for every status pattern while disabled
        for (int v = 0; v < 256; v++) begin
            {live_eof, live_crc_err, live_overrun, live_parity_err, live_residue, live_all_sent} = 8'(v);
            @(negedge clk);
            chk("R9", "passthrough", status_reg, 8'(v));
        end
        live_eof = 1'b0;

        queue_en = 1'b1;
        sdlc_mode = 1'b1;
        @(negedge clk);
        check_all("R11/R8 empty enabled");

        // R3 R6 R7 R8: fill the ring with varied counts and residue codes
        for (int i = 0; i < D; i++) begin
            send_bytes(i * 61 + (i % 3));
            end_frame(3'(i), i[0], i[1], 1'b0);
            live_all_sent = i[1];
            live_parity_err = i[0];
            @(negedge clk);
            check_all("R3 fill");
        end

        // R4: one more frame while full is dropped, overflow sets
        send_bytes(7);
        end_frame(3'd5, 1'b1, 1'b1, 1'b0);
        check_all("R4 overflow");

        // R7 R10: drain in order
        for (int i = 0; i < D; i++) begin
            pop_one();
            check_all("R7 R10 drain");
        end
        check_all("R6 empty after drain");
        chk("R5", "ovf kept after drain", count_hi_reg[7], 1'b1);

        pop_one();
        check_all("R10 pop on empty");

        // R2: strobes outside SDLC mode are ignored
        sdlc_mode = 1'b0;
        mcount = 0;
        send_bytes(20);
        end_frame(3'd7, 1'b1, 1'b0, 1'b0);
        check_all("R2 no file outside SDLC");
        sdlc_mode = 1'b1;
        send_bytes(3);
        end_frame(3'd2, 1'b0, 1'b1, 1'b0);
        check_all("R2 counter restarted");
        pop_one();

        // R1: byte in the flag cycle is not counted
        send_bytes(4);
        end_frame(3'd1, 1'b0, 1'b0, 1'b1);
        end_frame(3'd6, 1'b1, 1'b0, 1'b0);
        check_all("R1 flag count 4");
        pop_one();
        check_all("R1 next frame count 0");
        pop_one();

        // R10: repeated partial fills so slot order wraps at shifting points
        for (int r = 0; r < 5; r++) begin
            for (int k = 0; k < 7; k++) begin
                send_bytes(r * 9 + k);
                end_frame(3'(k + r), k[1], k[0], 1'b0);
            end
            check_all("R10 wrap fill");
            for (int k = 0; k < 7; k++) begin
                pop_one();
                check_all("R10 wrap drain");
            end
        end

        // R2: counter extremes
        send_bytes(CMAX - 1);
        end_frame(3'd3, 1'b0, 1'b0, 1'b0);
        send_bytes(CMAX + 5);
        end_frame(3'd4, 1'b0, 1'b0, 1'b0);
        check_all("R2 max count");
        pop_one();
        check_all("R2 count wrap");
        pop_one();

        // R5 R9: disabling clears overflow and queue
        end_frame(3'd1, 1'b0, 1'b0, 1'b0);
        queue_en = 1'b0;
        @(negedge clk);
        clear_model();
        check_all("R9 disabled views");
        queue_en = 1'b1;
        @(negedge clk);
        check_all("R5 disable clears overflow");

        // R5: reset clears overflow
        for (int i = 0; i <= D; i++) begin
            send_bytes(2);
            end_frame(3'd0, 1'b1, 1'b0, 1'b0);
        end
        chk("R5", "ovf before reset", count_hi_reg[7], 1'b1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        clear_model();
        @(negedge clk);
        check_all("R5 reset clears overflow");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule